// File: doc/BRIEF.md
# Divide-by-Three Processor Clock Generator

This block turns a fast oscillator clock into the clocks a small processor system needs. A strap input picks one of two digital clock sources. The chosen source is passed straight out as a buffered oscillator clock. It is also divided by three to form a processor clock, which is high for one source period in every three. The processor clock is halved again into a peripheral clock with an even duty cycle.

A phase-alignment input holds both dividers cleared while it is high. Several generators that share the same source and release this input on the same edge then produce processor and peripheral clocks that line up exactly. The alignment input must already be synchronous to the selected source. When the crystal source is used alone, it is tied low.

An active-low reset request is resampled on every falling edge of the processor clock. The result is an active-high system reset that changes only while the processor clock is low. The block has no data stream: every pin is a plain clock or a control level.

Top module: `cpu_clkgen`

## Requirements
- R1: In steady running, `cpu_clk` rises once every 3 periods of the selected source clock.
- R2: `cpu_clk` is high for exactly 1 source period out of every 3.
- R3: `per_clk` changes level only on source edges where `cpu_clk` rises, and toggles on every such edge. This gives a period of 6 source cycles and a 50% duty cycle.
- R4: `src_sel` = 0 selects `xtal_clk` and `src_sel` = 1 selects `ext_clk`. `osc_out` follows the selected clock at all times.
- R5: Any source rising edge that samples `phase_sync` = 1 leaves `cpu_clk` = 0 and `per_clk` = 0 after that edge.
- R6: The first source rising edge that samples `phase_sync` = 0 after a hold drives both `cpu_clk` and `per_clk` to 1. The 3-cycle pattern then runs from that edge.
- R7: After each falling edge of `cpu_clk`, `sys_rst` equals the inverse of the `rst_req_n` value sampled at that edge.
- R8: `sys_rst` changes only at a falling edge of `cpu_clk`, so it never changes while `cpu_clk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal-derived source clock (selected when `src_sel` = 0) |
| ext_clk | input | 1 | External frequency source clock (selected when `src_sel` = 1) |
| src_sel | input | 1 | Source strap: 0 = `xtal_clk`, 1 = `ext_clk` |
| phase_sync | input | 1 | Active-high divider clear, synchronous to the selected source |
| rst_req_n | input | 1 | Active-low reset request |
| osc_out | output | 1 | Buffered copy of the selected source clock |
| cpu_clk | output | 1 | Processor clock: source/3, 1/3 duty cycle |
| per_clk | output | 1 | Peripheral clock: `cpu_clk`/2, 50% duty cycle |
| sys_rst | output | 1 | Active-high system reset, updated on `cpu_clk` falling edges |

## Verification
A divide counter that skips or repeats a state shows up within three source cycles. It appears as a `cpu_clk` pulse that is too wide, too narrow or out of step. A stuck or doubled peripheral toggle puts `per_clk` out of phase by the next `cpu_clk` rise. A missing clear on the alignment input is visible on the very first edge after release. That first edge must raise both clocks. A wrong reset sampling edge or a wrong polarity shows on `sys_rst` at the first processor-clock fall after the request changes.

// File: rtl/cpu_clkgen_pkg.sv
package cpu_clkgen_pkg;
  localparam int unsigned DFLT_DIV_RATIO   = 3;
  localparam int unsigned DFLT_HIGH_CYCLES = 1;
  localparam int unsigned DFLT_RST_STAGES  = 1;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cpu_clkgen_src_mux.sv
module cpu_clkgen_src_mux (
  input  logic xtal_clk,
  input  logic ext_clk,
  input  logic src_sel,
  output logic clk_o
);
  assign clk_o = src_sel ? ext_clk : xtal_clk;
endmodule

// File: rtl/cpu_clkgen_div.sv
module cpu_clkgen_div
  import cpu_clkgen_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = DFLT_DIV_RATIO,
  parameter int unsigned HIGH_CYCLES = DFLT_HIGH_CYCLES
) (
  input  logic clk,
  input  logic hold,
  output logic cpu_q,
  output logic rise_now
);
  localparam int unsigned W = cnt_width(DIV_RATIO);
  localparam logic [W-1:0] LAST  = W'(DIV_RATIO - 1);
  localparam logic [W-1:0] HI_LIM = W'(HIGH_CYCLES);

  logic [W-1:0] phase;

  // phase 0 marks the edge on which the processor clock rises
  always_ff @(posedge clk) begin
    if (hold) begin
      phase <= '0;
      cpu_q <= 1'b0;
    end else begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
      cpu_q <= (phase < HI_LIM);
    end
  end

  assign rise_now = !hold && (phase == '0);
endmodule

// File: rtl/cpu_clkgen_per_div.sv
module cpu_clkgen_per_div (
  input  logic clk,
  input  logic hold,
  input  logic rise_now,
  output logic per_q
);
  always_ff @(posedge clk) begin
    if (hold)          per_q <= 1'b0;
    else if (rise_now) per_q <= ~per_q;
  end
endmodule

// File: rtl/cpu_clkgen_rst_sync.sv
module cpu_clkgen_rst_sync
  import cpu_clkgen_pkg::*;
#(
  parameter int unsigned STAGES = DFLT_RST_STAGES
) (
  input  logic cpu_clk,
  input  logic rst_req_n,
  output logic sys_rst
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(negedge cpu_clk) chain <= ~rst_req_n;
    end else begin : g_multi
      always_ff @(negedge cpu_clk) chain <= {chain[STAGES-2:0], ~rst_req_n};
    end
  endgenerate

  assign sys_rst = chain[STAGES-1];
endmodule

// File: rtl/cpu_clkgen.sv
module cpu_clkgen
  import cpu_clkgen_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = DFLT_DIV_RATIO,
  parameter int unsigned HIGH_CYCLES = DFLT_HIGH_CYCLES,
  parameter int unsigned RST_STAGES  = DFLT_RST_STAGES
) (
  input  logic xtal_clk,
  input  logic ext_clk,
  input  logic src_sel,
  input  logic phase_sync,
  input  logic rst_req_n,
  output logic osc_out,
  output logic cpu_clk,
  output logic per_clk,
  output logic sys_rst
);
  logic osc_clk;
  logic rise_now;

  cpu_clkgen_src_mux u_mux (
    .xtal_clk (xtal_clk),
    .ext_clk  (ext_clk),
    .src_sel  (src_sel),
    .clk_o    (osc_clk)
  );

  cpu_clkgen_div #(.DIV_RATIO(DIV_RATIO), .HIGH_CYCLES(HIGH_CYCLES)) u_div (
    .clk      (osc_clk),
    .hold     (phase_sync),
    .cpu_q    (cpu_clk),
    .rise_now (rise_now)
  );

  cpu_clkgen_per_div u_per (
    .clk      (osc_clk),
    .hold     (phase_sync),
    .rise_now (rise_now),
    .per_q    (per_clk)
  );

  cpu_clkgen_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .cpu_clk   (cpu_clk),
    .rst_req_n (rst_req_n),
    .sys_rst   (sys_rst)
  );

  assign osc_out = osc_clk;
endmodule

// File: rtl/cpu_clkgen_chk.sv
module cpu_clkgen_chk #(
  parameter int unsigned DIV_RATIO   = 3,
  parameter int unsigned HIGH_CYCLES = 1
) (
  input logic osc_out,
  input logic phase_sync,
  input logic cpu_clk,
  input logic per_clk,
  input logic sys_rst
);
  logic [15:0] gap;
  logic [15:0] hi_run;
  logic        seen_rise;
  logic        cpu_prev;
  logic        per_prev;

  always_ff @(posedge osc_out) begin
    if (phase_sync) begin
      gap <= '0; hi_run <= '0; seen_rise <= 1'b0;
      cpu_prev <= 1'b0; per_prev <= 1'b0;
    end else begin
      cpu_prev <= cpu_clk;
      per_prev <= per_clk;
      if (cpu_clk && !cpu_prev) begin
        gap <= 16'd1; seen_rise <= 1'b1;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 16'd1;
      end
      if (cpu_clk) hi_run <= (hi_run != 16'hFFFF) ? hi_run + 16'd1 : hi_run;
      else         hi_run <= '0;
    end
  end

  AST_RISE_PERIOD: assert property (@(posedge osc_out) disable iff (phase_sync)
    (cpu_clk && !cpu_prev && seen_rise) |-> (gap == 16'(DIV_RATIO))); // R1
  AST_HIGH_WIDTH: assert property (@(posedge osc_out) disable iff (phase_sync)
    (!cpu_clk && cpu_prev) |-> (hi_run == 16'(HIGH_CYCLES))); // R2
  AST_PER_ON_RISE: assert property (@(posedge osc_out) disable iff (phase_sync)
    (per_clk != per_prev) |-> (cpu_clk && !cpu_prev)); // R3
  AST_HOLD_CLEARS: assert property (@(posedge osc_out)
    $past(phase_sync) |-> (!cpu_clk && !per_clk)); // R5
  AST_FIRST_RISE: assert property (@(posedge osc_out) disable iff (phase_sync)
    $fell(phase_sync) |=> (cpu_clk && per_clk)); // R6
  AST_RST_LOW_ONLY: assert property (@(posedge osc_out) disable iff (phase_sync)
    (sys_rst != $past(sys_rst)) |-> !cpu_clk); // R8
endmodule

bind cpu_clkgen cpu_clkgen_chk #(.DIV_RATIO(DIV_RATIO), .HIGH_CYCLES(HIGH_CYCLES)) u_chk (
  .osc_out    (osc_out),
  .phase_sync (phase_sync),
  .cpu_clk    (cpu_clk),
  .per_clk    (per_clk),
  .sys_rst    (sys_rst)
);

// File: tb/cpu_clkgen_test.sv
module cpu_clkgen_test;
  localparam int CLK_PERIOD = 10;
  localparam int EXT_PERIOD = 14;
  localparam int DIV  = 3;
  localparam int HIGH = 1;

  logic xtal_clk = 1'b0, ext_clk = 1'b0;
  logic src_sel, phase_sync, rst_req_n;
  logic osc_out, cpu_clk, per_clk, sys_rst;

  int checks = 0, errors = 0;
  int n = 0;
  bit prev_ec = 1'b0, rst_valid = 1'b0, finished = 1'b0;
  logic rst_exp = 1'b0;

  cpu_clkgen uut (
    .xtal_clk(xtal_clk), .ext_clk(ext_clk), .src_sel(src_sel),
    .phase_sync(phase_sync), .rst_req_n(rst_req_n), .osc_out(osc_out),
    .cpu_clk(cpu_clk), .per_clk(per_clk), .sys_rst(sys_rst)
  );

  always #(CLK_PERIOD/2) xtal_clk = ~xtal_clk;
  always #(EXT_PERIOD/2) ext_clk  = ~ext_clk;

  function automatic logic exp_cpu(input int idx);
    return (idx % DIV) < HIGH;
  endfunction

  function automatic logic exp_per(input int idx);
    return ((idx / DIV) % 2) == 0;
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(input bit s, input bit r);
    logic ec, ep;
    string tc, tp;
    @(negedge osc_out);
    phase_sync = s;
    rst_req_n  = r;
    @(posedge osc_out);
    #1;
    if (s) begin
      ec = 1'b0; ep = 1'b0; n = 0; tc = "R5"; tp = "R5";
    end else begin
      ec = exp_cpu(n); ep = exp_per(n);
      tc = (n == 0) ? "R6" : "R1 R2";
      tp = (n == 0) ? "R6" : "R3";
      n++;
    end
    if (prev_ec && !ec) begin
      rst_exp   = ~r;
      rst_valid = 1'b1;
    end
    prev_ec = ec;
    check(tc, cpu_clk, ec);
    check(tp, per_clk, ep);
    check("R4", osc_out, src_sel ? ext_clk : xtal_clk);
    if (rst_valid) check("R7 R8", sys_rst, rst_exp);
  endtask

  task automatic pick_source(input bit v);
    @(negedge osc_out);
    phase_sync = 1'b1;
    src_sel = v;
    repeat (3) step(1'b1, rst_req_n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    src_sel = 1'b0; phase_sync = 1'b1; rst_req_n = 1'b0;
    // reset state while held (R5)
    repeat (4) step(1'b1, 1'b0);
    // directed: release, run with reset requested then withdrawn (R6, R7)
    repeat (12) step(1'b0, 1'b0);
    repeat (12) step(1'b0, 1'b1);
    // single-cycle hold mid-pattern, then resume (R5, R6)
    step(1'b1, 1'b1);
    repeat (10) step(1'b0, 1'b1);
    // hold landing while cpu_clk high
    repeat (3) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    repeat (8) step(1'b0, 1'b0);
    // external source (R4)
    pick_source(1'b1);
    repeat (20) step(1'b0, 1'b1);
    // random segments
    for (int seg = 0; seg < 30; seg++) begin
      if ($urandom_range(0, 3) == 0) pick_source(1'(($urandom_range(0, 1))));
      for (int h = 0; h < int'($urandom_range(1, 4)); h++) step(1'b1, rst_req_n);
      for (int c = 0; c < int'($urandom_range(10, 70)); c++)
        step(1'b0, ($urandom_range(0, 7) == 0) ? ~rst_req_n : rst_req_n);
    end
    summary();
  end
endmodule